// File: doc/BRIEF.md
# Four-Channel Match Timer

A register-mapped timer with four independent counter channels that share one prescaler. Each channel counts up or down once per prescaler period while enabled, and compares its count against its own match value. On a match, three per-channel actions can be chosen: latch an interrupt flag, reload the count with zero, or stop the channel by clearing its enable bit. The flags drive one level interrupt line.

Software reaches the timer through a single-cycle register port. Writes take effect at the next clock edge. Read data is a combinational function of the address. Every register occupies a 16-byte slot. Address bits [3:2] choose how a write acts:

- 0: plain write.
- 1: OR the written value into the register.
- 2: clear the bits that are 1 in the written value.
- 3: toggle the bits that are 1 in the written value.

Top module: `match_timer`

## Requirements
- R1: The slot is address bits [ADDR_W-1:4] and the write operation is address bits [3:2]. The operations are 0 plain, 1 OR-in, 2 clear the written ones, and 3 toggle the written ones. The interrupt-flag register is the one exception to the plain operation (see R9).
- R2: The slots are:
  - 0x00: flags.
  - 0x01: control.
  - 0x02: direction.
  - 0x03 to 0x06: counters 0 to 3, read-only.
  - 0x07: prescale value.
  - 0x08: prescale counter, read-only.
  - 0x09: match control.
  - 0x0A to 0x0D: match values 0 to 3.
  - 0x18: counter mode, 8 bits, stored with no effect.
  - Any other slot reads 0. Writes to the read-only slots change nothing.
- R3: Control bits 0 to 3 enable channels 0 to 3, and bits 4 to 7 are the channel reset bits. While a reset bit is 1, that counter reads 0 from the next edge on and holds there. While any reset bit is 1, the prescale counter is also held at 0. A channel that is disabled and not in reset holds its count.
- R4: The direction field of channel n is bits [4n+3:4n]. Value 1 counts down and any other value counts up. Counts wrap between 0 and all ones in both directions, and a wrap by itself sets no flag.
- R5: With prescale value P, enabled counters step once every P+1 clocks. The prescale counter reads 0 to P while any channel is enabled and no reset bit is set. Otherwise it reads 0. P = 0 steps the counters on every clock.
- R6: Flag n is bit n of the flag slot. It is set at the edge that ends a cycle in which channel n is enabled, is not in reset, and its count equals its match value. This happens regardless of the interrupt enable. Flag bits 4 and above read 0.
- R7: With match-control bit 3n+1 set, a match reloads counter n with 0 at that same edge.
- R8: With match-control bit 3n+2 set, a match clears control bit n at that edge and the count holds its value.
- R9: Writing 1s to the flag slot at the plain offset clears those flags. A match in the same cycle keeps its flag set.
- R10: The irq output is high while any flag n is set whose match-control bit 3n is also set.
- R11: After reset, every register, counter and flag reads 0 and irq is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWe | input | 1 | Write strobe, acts at the next edge |
| busAddr | input | ADDR_W | Byte address: slot and write operation |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr, zero-extended |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the timer with CNT_W = 8 and the default ADDR_W = 12. The 8-bit counters wrap in 256 steps, so up-count and down-count wraps and repeated matches fall within a short run. A behavioural model predicts every register and the interrupt each clock. The bench checks the model against the read port at a watched address and against irq. The sequence also times a flag clear to land in a match cycle, and runs the prescaler with P = 3 while reading both the prescale counter and a channel counter.

// File: rtl/match_timer_pkg.sv
package match_timer_pkg;
  localparam int TMR_CH = 4;
  localparam int BUS_W  = 32;

  localparam int SLOT_IRQ  = 0;
  localparam int SLOT_CTRL = 1;
  localparam int SLOT_DIR  = 2;
  localparam int SLOT_CNT0 = 3;
  localparam int SLOT_PRE  = 7;
  localparam int SLOT_PCNT = 8;
  localparam int SLOT_MCR  = 9;
  localparam int SLOT_MR0  = 10;
  localparam int SLOT_MODE = 24;

  typedef enum logic [1:0] {WR_PLAIN, WR_SET, WR_CLR, WR_TGL} wrOp_t;

  // strobes from the register file to the counters
  typedef struct packed {
    logic [TMR_CH-1:0] run;
    logic [TMR_CH-1:0] clr;
    logic [TMR_CH-1:0] down;
    logic [TMR_CH-1:0] resOnHit;
    logic [TMR_CH-1:0] stopOnHit;
  } chanCtl_t;

  function automatic logic [BUS_W-1:0] wrUpdate(input logic sel, input wrOp_t op,
                                                input logic [BUS_W-1:0] oldV,
                                                input logic [BUS_W-1:0] wd);
    logic [BUS_W-1:0] r;
    r = oldV;
    if (sel) begin
      unique case (op)
        WR_PLAIN: r = wd;
        WR_SET:   r = oldV | wd;
        WR_CLR:   r = oldV & ~wd;
        WR_TGL:   r = oldV ^ wd;
      endcase
    end
    return r;
  endfunction
endpackage

// File: rtl/match_timer_ctrl.sv
module match_timer_ctrl
  import match_timer_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 12
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           busWe,
  input  logic [ADDR_W-1:0]              busAddr,
  input  logic [BUS_W-1:0]               busWdata,
  output logic [BUS_W-1:0]               busRdata,
  input  logic [TMR_CH-1:0]              hit,
  input  logic [TMR_CH-1:0][CNT_W-1:0]   cnt,
  input  logic [CNT_W-1:0]               preCnt,
  output chanCtl_t                       chanCtl,
  output logic [CNT_W-1:0]               preVal,
  output logic [TMR_CH-1:0][CNT_W-1:0]   matchVal,
  output logic [TMR_CH-1:0]              flags,
  output logic                           irq
);
  localparam int SLOT_W = ADDR_W - 4;

  logic [SLOT_W-1:0] slot;
  wrOp_t             op;
  assign slot = busAddr[ADDR_W-1:4];
  assign op   = wrOp_t'(busAddr[3:2]);

  logic [TMR_CH-1:0]   flagReg;
  logic [2*TMR_CH-1:0] ctrlReg;
  logic [4*TMR_CH-1:0] dirReg;
  logic [CNT_W-1:0]    preReg;
  logic [3*TMR_CH-1:0] mcrReg;
  logic [2*TMR_CH-1:0] modeReg;
  logic [TMR_CH-1:0]   intEn;
  logic [TMR_CH-1:0]   stopHit;

  logic selIrq, selCtrl, selDir, selPre, selMcr, selMode;
  assign selIrq  = busWe && (slot == SLOT_W'(SLOT_IRQ));
  assign selCtrl = busWe && (slot == SLOT_W'(SLOT_CTRL));
  assign selDir  = busWe && (slot == SLOT_W'(SLOT_DIR));
  assign selPre  = busWe && (slot == SLOT_W'(SLOT_PRE));
  assign selMcr  = busWe && (slot == SLOT_W'(SLOT_MCR));
  assign selMode = busWe && (slot == SLOT_W'(SLOT_MODE));

  logic [BUS_W-1:0] flagUpd, ctrlUpd, dirUpd, preUpd, mcrUpd, modeUpd;
  assign flagUpd = (selIrq && op == WR_PLAIN) ? (BUS_W'(flagReg) & ~busWdata)
                                              : wrUpdate(selIrq, op, BUS_W'(flagReg), busWdata);
  assign ctrlUpd = wrUpdate(selCtrl, op, BUS_W'(ctrlReg), busWdata);
  assign dirUpd  = wrUpdate(selDir,  op, BUS_W'(dirReg),  busWdata);
  assign preUpd  = wrUpdate(selPre,  op, BUS_W'(preReg),  busWdata);
  assign mcrUpd  = wrUpdate(selMcr,  op, BUS_W'(mcrReg),  busWdata);
  assign modeUpd = wrUpdate(selMode, op, BUS_W'(modeReg), busWdata);

  assign stopHit = hit & chanCtl.stopOnHit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagReg <= '0;
      ctrlReg <= '0;
      dirReg  <= '0;
      preReg  <= '0;
      mcrReg  <= '0;
      modeReg <= '0;
    end else begin
      flagReg <= flagUpd[TMR_CH-1:0] | hit;
      ctrlReg <= ctrlUpd[2*TMR_CH-1:0] & ~{{TMR_CH{1'b0}}, stopHit};
      dirReg  <= dirUpd[4*TMR_CH-1:0];
      preReg  <= preUpd[CNT_W-1:0];
      mcrReg  <= mcrUpd[3*TMR_CH-1:0];
      modeReg <= modeUpd[2*TMR_CH-1:0];
    end
  end

  for (genvar n = 0; n < TMR_CH; n++) begin : gChan
    logic             selMr;
    logic [BUS_W-1:0] mrUpd;
    logic [CNT_W-1:0] mrReg;
    assign selMr = busWe && (slot == SLOT_W'(SLOT_MR0 + n));
    assign mrUpd = wrUpdate(selMr, op, BUS_W'(mrReg), busWdata);
    always_ff @(posedge clk) begin
      if (!rstN) mrReg <= '0;
      else       mrReg <= mrUpd[CNT_W-1:0];
    end
    assign matchVal[n]           = mrReg;
    assign chanCtl.down[n]       = (dirReg[4*n +: 4] == 4'd1);
    assign intEn[n]              = mcrReg[3*n];
    assign chanCtl.resOnHit[n]   = mcrReg[3*n+1];
    assign chanCtl.stopOnHit[n]  = mcrReg[3*n+2];
  end

  assign chanCtl.run = ctrlReg[TMR_CH-1:0];
  assign chanCtl.clr = ctrlReg[2*TMR_CH-1:TMR_CH];
  assign preVal      = preReg;
  assign flags       = flagReg;
  assign irq         = |(flagReg & intEn);

  always_comb begin
    busRdata = '0;
    case (slot)
      SLOT_W'(SLOT_IRQ):  busRdata = BUS_W'(flagReg);
      SLOT_W'(SLOT_CTRL): busRdata = BUS_W'(ctrlReg);
      SLOT_W'(SLOT_DIR):  busRdata = BUS_W'(dirReg);
      SLOT_W'(SLOT_PRE):  busRdata = BUS_W'(preReg);
      SLOT_W'(SLOT_PCNT): busRdata = BUS_W'(preCnt);
      SLOT_W'(SLOT_MCR):  busRdata = BUS_W'(mcrReg);
      SLOT_W'(SLOT_MODE): busRdata = BUS_W'(modeReg);
      default:            busRdata = '0;
    endcase
    for (int n = 0; n < TMR_CH; n++) begin
      if (slot == SLOT_W'(SLOT_CNT0 + n)) busRdata = BUS_W'(cnt[n]);
      if (slot == SLOT_W'(SLOT_MR0 + n))  busRdata = BUS_W'(matchVal[n]);
    end
  end
endmodule

// File: rtl/match_timer_dpath.sv
module match_timer_dpath
  import match_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  chanCtl_t                       chanCtl,
  input  logic [CNT_W-1:0]               preVal,
  input  logic [TMR_CH-1:0][CNT_W-1:0]   matchVal,
  output logic [TMR_CH-1:0][CNT_W-1:0]   cnt,
  output logic [CNT_W-1:0]               preCnt,
  output logic [TMR_CH-1:0]              hit
);
  logic anyRun, anyClr, preWrap, tick;
  assign anyRun  = |chanCtl.run;
  assign anyClr  = |chanCtl.clr;
  assign preWrap = (preCnt == preVal);
  assign tick    = anyRun && !anyClr && preWrap;

  always_ff @(posedge clk) begin
    if (!rstN || !anyRun || anyClr) preCnt <= '0;
    else if (preWrap)               preCnt <= '0;
    else                            preCnt <= preCnt + 1'b1;
  end

  for (genvar n = 0; n < TMR_CH; n++) begin : gCnt
    logic [CNT_W-1:0] cntQ;
    assign hit[n] = chanCtl.run[n] && !chanCtl.clr[n] && (cntQ == matchVal[n]);
    always_ff @(posedge clk) begin
      if (!rstN || chanCtl.clr[n])             cntQ <= '0;
      else if (hit[n] && chanCtl.resOnHit[n])  cntQ <= '0;
      else if (hit[n] && chanCtl.stopOnHit[n]) cntQ <= cntQ;
      else if (tick && chanCtl.run[n])
        cntQ <= chanCtl.down[n] ? cntQ - 1'b1 : cntQ + 1'b1;
    end
    assign cnt[n] = cntQ;
  end
endmodule

// File: rtl/match_timer.sv
module match_timer
  import match_timer_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              irq
);
  chanCtl_t                     chanCtl;
  logic [CNT_W-1:0]             preVal, preCnt;
  logic [TMR_CH-1:0][CNT_W-1:0] matchVal, cnt;
  logic [TMR_CH-1:0]            hit, flags;

  match_timer_ctrl #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .hit(hit), .cnt(cnt),
    .preCnt(preCnt), .chanCtl(chanCtl), .preVal(preVal),
    .matchVal(matchVal), .flags(flags), .irq(irq)
  );

  match_timer_dpath #(.CNT_W(CNT_W)) u_dpath (
    .clk(clk), .rstN(rstN), .chanCtl(chanCtl), .preVal(preVal),
    .matchVal(matchVal), .cnt(cnt), .preCnt(preCnt), .hit(hit)
  );
endmodule

// File: rtl/match_timer_chk.sv
module match_timer_chk
  import match_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic                         clk,
  input logic                         rstN,
  input chanCtl_t                     chanCtl,
  input logic [TMR_CH-1:0][CNT_W-1:0] cnt,
  input logic [TMR_CH-1:0]            hit,
  input logic [TMR_CH-1:0]            flags
);
  for (genvar n = 0; n < TMR_CH; n++) begin : gProp
    AST_CLR_HOLDS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
      $past(chanCtl.clr[n]) |-> cnt[n] == '0); // R3
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
      $past(!chanCtl.run[n] && !chanCtl.clr[n]) |-> cnt[n] == $past(cnt[n])); // R3
    AST_HIT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
      $past(hit[n]) |-> flags[n]); // R6
    AST_HIT_RELOADS: assert property (@(posedge clk) disable iff (!rstN)
      $past(hit[n] && chanCtl.resOnHit[n]) |-> cnt[n] == '0); // R7
    AST_HIT_STOPS: assert property (@(posedge clk) disable iff (!rstN)
      $past(hit[n] && chanCtl.stopOnHit[n]) |-> !chanCtl.run[n]); // R8
  end
endmodule

bind match_timer match_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .chanCtl(chanCtl), .cnt(cnt), .hit(hit), .flags(flags)
);

// File: tb/sim_match_timer.sv
module sim_match_timer;
  localparam int W = 8;
  localparam logic [31:0] MSK = 32'hFF;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWe = 1'b0;
  logic [11:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        irq;

  always #5 clk = ~clk;

  match_timer #(.CNT_W(W), .ADDR_W(12)) u0 (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .irq(irq)
  );

  int    nChecks = 0;
  int    nErr = 0;
  string curReq = "R11";

  logic [31:0] mFlag, mCtrl, mDir, mPr, mPc, mMcr, mMode;
  logic [31:0] mMr [4];
  logic [31:0] mCnt [4];

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s %s: actual %h expected %h", curReq, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mRead(input logic [11:0] a);
    int s;
    s = int'(a[11:4]);
    case (s)
      0:  return mFlag;
      1:  return mCtrl;
      2:  return mDir;
      3, 4, 5, 6: return mCnt[s-3];
      7:  return mPr;
      8:  return mPc;
      9:  return mMcr;
      10, 11, 12, 13: return mMr[s-10];
      24: return mMode;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] opApply(input int o, input logic [31:0] oldV, input logic [31:0] wd);
    case (o)
      0: return wd;
      1: return oldV | wd;
      2: return oldV & ~wd;
      default: return oldV ^ wd;
    endcase
  endfunction

  function automatic logic mIrq();
    logic r;
    r = 1'b0;
    for (int n = 0; n < 4; n++) if (mFlag[n] && mMcr[3*n]) r = 1'b1;
    return r;
  endfunction

  task automatic modelClear();
    mFlag = 0; mCtrl = 0; mDir = 0; mPr = 0; mPc = 0; mMcr = 0; mMode = 0;
    for (int n = 0; n < 4; n++) begin mMr[n] = 0; mCnt[n] = 0; end
  endtask

  task automatic cyc(input logic we, input logic [11:0] a, input logic [31:0] wd);
    logic [3:0] en, rb, hitv, stopv;
    logic tk;
    int s, o;
    @(negedge clk);
    busWe = we; busAddr = a; busWdata = wd;
    #1;
    chk(busRdata, mRead(a), $sformatf("read @%h", a));
    chk({31'b0, irq}, {31'b0, mIrq()}, "irq");
    @(posedge clk);
    en = mCtrl[3:0]; rb = mCtrl[7:4];
    for (int n = 0; n < 4; n++) begin
      hitv[n]  = en[n] && !rb[n] && (mCnt[n] == mMr[n]);
      stopv[n] = hitv[n] && mMcr[3*n+2];
    end
    tk = (|en) && !(|rb) && (mPc == mPr);
    for (int n = 0; n < 4; n++) begin
      if (rb[n]) mCnt[n] = 0;
      else if (hitv[n] && mMcr[3*n+1]) mCnt[n] = 0;
      else if (hitv[n] && mMcr[3*n+2]) mCnt[n] = mCnt[n];
      else if (tk && en[n])
        mCnt[n] = (mDir[4*n +: 4] == 4'd1) ? ((mCnt[n] - 1) & MSK) : ((mCnt[n] + 1) & MSK);
    end
    if (!(|en) || (|rb) || mPc == mPr) mPc = 0;
    else mPc = (mPc + 1) & MSK;
    if (we) begin
      s = int'(a[11:4]); o = int'(a[3:2]);
      case (s)
        0: mFlag = ((o == 0) ? (mFlag & ~wd) : opApply(o, mFlag, wd)) & 32'hF;
        1: mCtrl = opApply(o, mCtrl, wd) & 32'hFF;
        2: mDir  = opApply(o, mDir, wd) & 32'hFFFF;
        7: mPr   = opApply(o, mPr, wd) & MSK;
        9: mMcr  = opApply(o, mMcr, wd) & 32'hFFF;
        10, 11, 12, 13: mMr[s-10] = opApply(o, mMr[s-10], wd) & MSK;
        24: mMode = opApply(o, mMode, wd) & 32'hFF;
        default: ;
      endcase
    end
    mFlag = mFlag | {28'b0, hitv};
    mCtrl = mCtrl & ~{28'b0, stopv};
  endtask

  task automatic watch(input logic [11:0] a, input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, a, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nErr++;
    $display("FAIL %s watchdog expired", curReq);
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin
    modelClear();
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;

    curReq = "R11";
    for (int s = 0; s < 16; s++) cyc(1'b0, 12'(s << 4), 32'h0);
    cyc(1'b0, 12'h180, 32'h0);

    curReq = "R1";
    cyc(1'b1, 12'h0A0, 32'h5A);
    cyc(1'b1, 12'h0A4, 32'h81);
    cyc(1'b1, 12'h0A8, 32'h10);
    cyc(1'b1, 12'h0AC, 32'hFF);
    cyc(1'b1, 12'h0B0, 32'h1234_56C3);
    watch(12'h0A0, 1);
    watch(12'h0B0, 1);

    curReq = "R2";
    cyc(1'b1, 12'h030, 32'h33);
    cyc(1'b1, 12'h080, 32'h07);
    cyc(1'b1, 12'h180, 32'hAB);
    cyc(1'b1, 12'h188, 32'h0F);
    watch(12'h030, 1);
    watch(12'h080, 1);
    watch(12'h180, 1);
    watch(12'h0E0, 1);

    curReq = "R6";
    cyc(1'b1, 12'h004, 32'h10);
    watch(12'h000, 1);
    cyc(1'b1, 12'h0B0, 32'h0);
    cyc(1'b1, 12'h090, 32'h001);
    cyc(1'b1, 12'h0A0, 32'd10);
    cyc(1'b1, 12'h014, 32'h1);
    curReq = "R10";
    watch(12'h030, 20);
    watch(12'h000, 2);

    curReq = "R9";
    cyc(1'b1, 12'h000, 32'h1);
    watch(12'h000, 2);
    cyc(1'b1, 12'h018, 32'h1);
    cyc(1'b1, 12'h014, 32'h10);
    cyc(1'b1, 12'h018, 32'h10);
    cyc(1'b1, 12'h0A0, 32'h0);
    cyc(1'b1, 12'h000, 32'hF);
    cyc(1'b1, 12'h014, 32'h1);
    cyc(1'b1, 12'h000, 32'h1);
    watch(12'h000, 2);
    cyc(1'b1, 12'h0A0, 32'h80);
    cyc(1'b1, 12'h000, 32'hF);

    curReq = "R7";
    cyc(1'b1, 12'h0B0, 32'd5);
    cyc(1'b1, 12'h094, 32'h010);
    cyc(1'b1, 12'h014, 32'h2);
    watch(12'h040, 16);

    curReq = "R8";
    cyc(1'b1, 12'h0C0, 32'd3);
    cyc(1'b1, 12'h094, 32'h140);
    cyc(1'b1, 12'h014, 32'h4);
    watch(12'h050, 6);
    watch(12'h010, 2);
    watch(12'h050, 3);

    curReq = "R4";
    cyc(1'b1, 12'h0D0, 32'h80);
    cyc(1'b1, 12'h024, 32'h1000);
    cyc(1'b1, 12'h024, 32'h0200);
    cyc(1'b1, 12'h014, 32'h8);
    watch(12'h060, 6);
    watch(12'h020, 1);
    for (int i = 0; i < 150; i++) cyc(1'b0, (i % 2 == 0) ? 12'h030 : 12'h000, 32'h0);

    curReq = "R5";
    cyc(1'b1, 12'h070, 32'd3);
    for (int i = 0; i < 12; i++) cyc(1'b0, (i % 2 == 0) ? 12'h080 : 12'h030, 32'h0);
    watch(12'h080, 8);

    curReq = "R3";
    cyc(1'b1, 12'h014, 32'h10);
    watch(12'h030, 5);
    watch(12'h080, 2);
    cyc(1'b1, 12'h018, 32'h10);
    watch(12'h030, 6);
    cyc(1'b1, 12'h018, 32'h1);
    watch(12'h030, 4);

    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end
endmodule